// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the target-side controller of a four-wire serial test port. A sixteen-state sequencer advances on every rising edge of the test clock, steered only by the mode-select input. An instruction is shifted in through a five-bit instruction register. The active instruction chooses which data path sits between the serial input and the serial output: a one-bit pass-through stage, a 32-bit identification register, or an external boundary chain. The controller drives the capture, shift and update strobes of that chain and a mode code for it.

The serial output is registered on the falling edge of the test clock. It comes with an output enable that is high only while a shift state is active, so a pad can turn it into a tri-state pin. The active-low test reset clears the sequencer asynchronously. The reset state also reloads the default instruction. Parameters set the identification value, whether the identification register exists, and whether the reset pin is used.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: `tap_state` follows the standard two-way transition graph on `tms` at each rising `tck`. The state codes are: 0 reset, 1 idle, 2 DR select, 3 DR capture, 4 DR shift, 5 DR exit1, 6 DR pause, 7 DR exit2, 8 DR update, 9 IR select, 10 IR capture, 11 IR shift, 12 IR exit1, 13 IR pause, 14 IR exit2, 15 IR update. State 0 holds while `tms` is 1.
- R2: From any state, five consecutive rising edges with `tms` high reach state 0.
- R3: `trst_n` low forces state 0 at once and clears `tdo_oe`, without waiting for a clock edge. Both this reset and a pass through state 0 make IDCODE the active instruction, or BYPASS when no identification register is built.
- R4: `tdo_oe` and `tdo_data` change only on falling `tck`. `tdo_oe` is 1 exactly in the half cycles that follow a falling edge in state 4 or state 11.
- R5: IR capture loads 5'b00001. IR shift moves the register one place toward bit 0 on each edge, with `tdi` entering at bit 4 and bit 0 sent out first. IR update makes the shifted value the active instruction.
- R6: The instruction codes are EXTEST 5'h00, IDCODE 5'h01, SAMPLE/PRELOAD 5'h02, INTEST 5'h03 and BYPASS 5'h1F. Every other code acts as BYPASS.
- R7: Under BYPASS, DR capture loads 0 and each DR shift delays `tdi` by one stage.
- R8: Under IDCODE, DR capture loads `ID_VALUE`, which is shifted out least significant bit first.
- R9: Under EXTEST, SAMPLE/PRELOAD or INTEST, `bsr_capture`, `bsr_shift` and `bsr_update` are high in states 3, 4 and 8 respectively, and `tdo` carries `bsr_so`. Under any other instruction all three strobes stay low.
- R10: `bsr_mode` is 2'b01 under EXTEST, 2'b10 under INTEST and 2'b00 otherwise.
- R11: The active instruction, and so `bsr_mode`, changes only in IR update or on reset. IR capture and shift leave it unchanged.
- R12: The pause states hold the data register contents, so a DR scan split by a pause returns the same bits as an unbroken scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| bsr_so | input | 1 | Serial return from the external boundary chain |
| tdo_data | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for the serial output pad |
| tap_state | output | 4 | Current sequencer state code |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_mode | output | 2 | Boundary chain mode: 00 functional, 01 pins driven, 10 core driven |

## Verification
Some properties are checked on every clock: the hold and exit edges of the sequencer, convergence to the reset state after five high mode bits, the output enable following the shift states, mutual exclusion of the chain strobes and their tie to the capture, shift and update states, and the active mode staying fixed outside IR update and reset. Other behaviour can only be shown by the bench scenarios, because it needs whole scans: the exact bit order of captured values, the one-stage delay of the bypass path, the mapping of each instruction code to a path, the handling of unknown codes, pause-split scans, and reset striking in the middle of a shift.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 5;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    TS_RESET    = 4'd0,
    TS_IDLE     = 4'd1,
    TS_DR_SEL   = 4'd2,
    TS_DR_CAP   = 4'd3,
    TS_DR_SHIFT = 4'd4,
    TS_DR_EXIT1 = 4'd5,
    TS_DR_PAUSE = 4'd6,
    TS_DR_EXIT2 = 4'd7,
    TS_DR_UPD   = 4'd8,
    TS_IR_SEL   = 4'd9,
    TS_IR_CAP   = 4'd10,
    TS_IR_SHIFT = 4'd11,
    TS_IR_EXIT1 = 4'd12,
    TS_IR_PAUSE = 4'd13,
    TS_IR_EXIT2 = 4'd14,
    TS_IR_UPD   = 4'd15
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BSR = 2'd2
  } dr_path_e;

  localparam logic [1:0] BMODE_FUNC = 2'b00;
  localparam logic [1:0] BMODE_EXT  = 2'b01;
  localparam logic [1:0] BMODE_INT  = 2'b10;

  localparam logic [IR_W-1:0] OP_EXTEST = 5'h00;
  localparam logic [IR_W-1:0] OP_IDCODE = 5'h01;
  localparam logic [IR_W-1:0] OP_SAMPLE = 5'h02;
  localparam logic [IR_W-1:0] OP_INTEST = 5'h03;
  localparam logic [IR_W-1:0] OP_BYPASS = {IR_W{1'b1}};
  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      TS_RESET:    return m ? TS_RESET    : TS_IDLE;
      TS_IDLE:     return m ? TS_DR_SEL   : TS_IDLE;
      TS_DR_SEL:   return m ? TS_IR_SEL   : TS_DR_CAP;
      TS_DR_CAP:   return m ? TS_DR_EXIT1 : TS_DR_SHIFT;
      TS_DR_SHIFT: return m ? TS_DR_EXIT1 : TS_DR_SHIFT;
      TS_DR_EXIT1: return m ? TS_DR_UPD   : TS_DR_PAUSE;
      TS_DR_PAUSE: return m ? TS_DR_EXIT2 : TS_DR_PAUSE;
      TS_DR_EXIT2: return m ? TS_DR_UPD   : TS_DR_SHIFT;
      TS_DR_UPD:   return m ? TS_DR_SEL   : TS_IDLE;
      TS_IR_SEL:   return m ? TS_RESET    : TS_IR_CAP;
      TS_IR_CAP:   return m ? TS_IR_EXIT1 : TS_IR_SHIFT;
      TS_IR_SHIFT: return m ? TS_IR_EXIT1 : TS_IR_SHIFT;
      TS_IR_EXIT1: return m ? TS_IR_UPD   : TS_IR_PAUSE;
      TS_IR_PAUSE: return m ? TS_IR_EXIT2 : TS_IR_PAUSE;
      TS_IR_EXIT2: return m ? TS_IR_UPD   : TS_IR_SHIFT;
      TS_IR_UPD:   return m ? TS_DR_SEL   : TS_IDLE;
      default:     return TS_RESET;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = tap_next(state, tms);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      state <= TS_RESET;
    end else begin
      state <= state_d;
    end
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
#(
  parameter logic [IR_W-1:0] RESET_OP = OP_IDCODE
) (
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_active,
  output logic            ir_so
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic            sr_en;
  logic            act_en;
  logic [IR_W-1:0] act_d;

  always_comb begin
    sr_en = 1'b0;
    sr_d  = sr_q;
    if (state == TS_IR_CAP) begin
      sr_en = 1'b1;
      sr_d  = IR_CAPTURE;
    end else if (state == TS_IR_SHIFT) begin
      sr_en = 1'b1;
      sr_d  = {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_comb begin
    act_en = 1'b0;
    act_d  = ir_active;
    if (state == TS_RESET) begin
      act_en = 1'b1;
      act_d  = RESET_OP;
    end else if (state == TS_IR_UPD) begin
      act_en = 1'b1;
      act_d  = sr_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= IR_CAPTURE;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_active <= RESET_OP;
    end else if (act_en) begin
      ir_active <= act_d;
    end
  end

  assign ir_so = sr_q[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter bit              ID_EN    = 1'b1,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4A5C_E0B3
) (
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  input  dr_path_e   path,
  output logic       byp_so,
  output logic       id_so
);

  logic byp_en, byp_d;

  always_comb begin
    byp_en = 1'b0;
    byp_d  = byp_so;
    if (path == PATH_BYP) begin
      if (state == TS_DR_CAP) begin
        byp_en = 1'b1;
        byp_d  = 1'b0;
      end else if (state == TS_DR_SHIFT) begin
        byp_en = 1'b1;
        byp_d  = tdi;
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_so <= 1'b0;
    end else if (byp_en) begin
      byp_so <= byp_d;
    end
  end

  generate
    if (ID_EN) begin : g_id
      logic [ID_W-1:0] id_q, id_d;
      logic            id_en;

      always_comb begin
        id_en = 1'b0;
        id_d  = id_q;
        if (path == PATH_ID) begin
          if (state == TS_DR_CAP) begin
            id_en = 1'b1;
            id_d  = ID_VALUE;
          end else if (state == TS_DR_SHIFT) begin
            id_en = 1'b1;
            id_d  = {tdi, id_q[ID_W-1:1]};
          end
        end
      end

      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
          id_q <= ID_VALUE;
        end else if (id_en) begin
          id_q <= id_d;
        end
      end

      assign id_so = id_q[0];
    end else begin : g_no_id
      assign id_so = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter bit              TRST_EN  = 1'b1,
  parameter bit              ID_EN    = 1'b1,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4A5C_E0B3
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  input  logic       tdi,
  input  logic       bsr_so,
  output logic       tdo_data,
  output logic       tdo_oe,
  output logic [3:0] tap_state,
  output logic       bsr_capture,
  output logic       bsr_shift,
  output logic       bsr_update,
  output logic [1:0] bsr_mode
);

  localparam logic [IR_W-1:0] RESET_OP = ID_EN ? OP_IDCODE : OP_BYPASS;

  logic            rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] ir_active;
  logic            ir_so;
  logic            byp_so;
  logic            id_so;
  dr_path_e        path;
  logic [1:0]      mode;
  logic            tdo_d;
  logic            oe_d;

  assign rst_n = TRST_EN ? trst_n : 1'b1;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  tap_ir #(.RESET_OP(RESET_OP)) u_ir (
    .tck       (tck),
    .rst_n     (rst_n),
    .state     (state),
    .tdi       (tdi),
    .ir_active (ir_active),
    .ir_so     (ir_so)
  );

  tap_dr #(.ID_EN(ID_EN), .ID_VALUE(ID_VALUE)) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .state  (state),
    .tdi    (tdi),
    .path   (path),
    .byp_so (byp_so),
    .id_so  (id_so)
  );

  // Instruction decode: unknown codes fall back to the one-bit path
  always_comb begin
    path = PATH_BYP;
    mode = BMODE_FUNC;
    case (ir_active)
      OP_EXTEST: begin path = PATH_BSR; mode = BMODE_EXT; end
      OP_SAMPLE: begin path = PATH_BSR; mode = BMODE_FUNC; end
      OP_INTEST: begin path = PATH_BSR; mode = BMODE_INT; end
      OP_IDCODE: path = ID_EN ? PATH_ID : PATH_BYP;
      default:   path = PATH_BYP;
    endcase
  end

  always_comb begin
    oe_d = (state == TS_DR_SHIFT) || (state == TS_IR_SHIFT);
    if (state == TS_IR_SHIFT) begin
      tdo_d = ir_so;
    end else begin
      case (path)
        PATH_ID:  tdo_d = id_so;
        PATH_BSR: tdo_d = bsr_so;
        default:  tdo_d = byp_so;
      endcase
    end
  end

  // Output stage launched on the falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_data <= 1'b0;
      tdo_oe   <= 1'b0;
    end else begin
      tdo_data <= tdo_d;
      tdo_oe   <= oe_d;
    end
  end

  assign tap_state   = state;
  assign bsr_mode    = mode;
  assign bsr_capture = (path == PATH_BSR) && (state == TS_DR_CAP);
  assign bsr_shift   = (path == PATH_BSR) && (state == TS_DR_SHIFT);
  assign bsr_update  = (path == PATH_BSR) && (state == TS_DR_UPD);

endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
module jtag_tap_ctrl_chk
  import jtag_tap_pkg::*;
(
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input logic [3:0] tap_state,
  input logic       tdo_oe,
  input logic       bsr_capture,
  input logic       bsr_shift,
  input logic       bsr_update,
  input logic [1:0] bsr_mode
);

  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      hi_cnt <= 3'd0;
    end else if (tms) begin
      hi_cnt <= (hi_cnt == 3'd5) ? 3'd5 : hi_cnt + 3'd1;
    end else begin
      hi_cnt <= 3'd0;
    end
  end

  a_r1_reset_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == TS_RESET && tms) |=> tap_state == TS_RESET);

  a_r1_drshift_stay: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == TS_DR_SHIFT && !tms) |=> tap_state == TS_DR_SHIFT);

  a_r1_drshift_exit: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == TS_DR_SHIFT && tms) |=> tap_state == TS_DR_EXIT1);

  a_r1_irsel_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == TS_IR_SEL && tms) |=> tap_state == TS_RESET);

  a_r2_five_high: assert property (@(posedge tck) disable iff (!trst_n)
    hi_cnt == 3'd5 |-> tap_state == TS_RESET);

  a_r4_oe_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (tap_state == TS_DR_SHIFT || tap_state == TS_IR_SHIFT));

  a_r9_strobe_excl: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  a_r9_capture_state: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_capture |-> tap_state == TS_DR_CAP);

  a_r9_shift_state: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_shift |-> tap_state == TS_DR_SHIFT);

  a_r9_update_state: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_update |-> tap_state == TS_DR_UPD);

  a_r11_mode_hold: assert property (@(posedge tck) disable iff (!trst_n)
    !($past(tap_state) == TS_IR_UPD || $past(tap_state) == TS_RESET)
      |-> $stable(bsr_mode));

endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk u_chk (
  .tck         (tck),
  .trst_n      (trst_n),
  .tms         (tms),
  .tap_state   (tap_state),
  .tdo_oe      (tdo_oe),
  .bsr_capture (bsr_capture),
  .bsr_shift   (bsr_shift),
  .bsr_update  (bsr_update),
  .bsr_mode    (bsr_mode)
);

// File: tb/tb_jtag_tap_ctrl.sv
`timescale 1ns/100ps
module tb_jtag_tap_ctrl;

  localparam logic [31:0] IDV = 32'h4A5C_E0B3;
  localparam logic [39:0] PAT = 40'hC3_5A96_E1F0;

  // {tms, expected state after the edge}
  localparam logic [4:0] WALK [45] = '{
    5'h10, 5'h01, 5'h01, 5'h12, 5'h19, 5'h10, 5'h01, 5'h12, 5'h03, 5'h15,
    5'h06, 5'h06, 5'h17, 5'h04, 5'h04, 5'h15, 5'h18, 5'h12, 5'h03, 5'h04,
    5'h15, 5'h06, 5'h17, 5'h18, 5'h01, 5'h12, 5'h19, 5'h0A, 5'h1C, 5'h0D,
    5'h0D, 5'h1E, 5'h0B, 5'h0B, 5'h1C, 5'h1F, 5'h12, 5'h19, 5'h0A, 5'h0B,
    5'h1C, 5'h0D, 5'h1E, 5'h1F, 5'h01
  };

  // {code, path kind (0 bypass, 1 id, 2 chain), expected mode}
  localparam logic [8:0] ITAB [7] = '{
    {5'h00, 2'd2, 2'b01},
    {5'h01, 2'd1, 2'b00},
    {5'h02, 2'd2, 2'b00},
    {5'h03, 2'd2, 2'b10},
    {5'h1F, 2'd0, 2'b00},
    {5'h05, 2'd0, 2'b00},
    {5'h1A, 2'd0, 2'b00}
  };

  logic       tck = 1'b0;
  logic       trst_n;
  logic       tms;
  logic       tdi;
  logic       bsr_so;
  logic       tdo_data;
  logic       tdo_oe;
  logic [3:0] tap_state;
  logic       bsr_capture;
  logic       bsr_shift;
  logic       bsr_update;
  logic [1:0] bsr_mode;

  int checks   = 0;
  int failures = 0;
  int upd_cnt  = 0;
  logic [3:0] chain;

  always #2 tck = ~tck;

  jtag_tap_ctrl dut (
    .tck         (tck),
    .trst_n      (trst_n),
    .tms         (tms),
    .tdi         (tdi),
    .bsr_so      (bsr_so),
    .tdo_data    (tdo_data),
    .tdo_oe      (tdo_oe),
    .tap_state   (tap_state),
    .bsr_capture (bsr_capture),
    .bsr_shift   (bsr_shift),
    .bsr_update  (bsr_update),
    .bsr_mode    (bsr_mode)
  );

  // Four-cell external chain model
  always @(posedge tck) begin
    if (bsr_capture) chain <= 4'hA;
    else if (bsr_shift) chain <= {tdi, chain[3:1]};
    if (bsr_update) upd_cnt <= upd_cnt + 1;
  end
  assign bsr_so = chain[0];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns the output seen before the rising edge
  task automatic step(input logic m, input logic d, output logic so, output logic oe);
    tms = m;
    tdi = d;
    so  = tdo_data;
    oe  = tdo_oe;
    @(posedge tck);
    @(negedge tck);
    #0.5;
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n,
                         output logic [63:0] dout, output logic oe_all);
    logic so, oe;
    dout = '0;
    oe_all = 1'b1;
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], so, oe);
      dout[i] = so;
      oe_all &= oe;
    end
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
  endtask

  task automatic scan_ir(input logic [4:0] code, output logic [4:0] dout, output logic oe_all);
    logic so, oe;
    dout = '0;
    oe_all = 1'b1;
    step(1'b1, 1'b0, so, oe);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, code[i], so, oe);
      dout[i] = so;
      oe_all &= oe;
    end
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic so, oe, oe_all;
    logic [63:0] dout;
    logic [4:0]  irout;
    int          u0;

    trst_n = 1'b0;
    tms = 1'b1;
    tdi = 1'b0;
    repeat (3) @(negedge tck);
    #0.5;
    check("R3 reset state", {60'd0, tap_state}, 64'd0);
    check("R4 reset oe", {63'd0, tdo_oe}, 64'd0);
    trst_n = 1'b1;

    // R1 state graph walk
    for (int i = 0; i < 45; i++) begin
      step(WALK[i][4], 1'b1, so, oe);
      check("R1 transition", {60'd0, tap_state}, {60'd0, WALK[i][3:0]});
    end

    // back to reset, then idle
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);

    // R3 reset loads IDCODE; R8 ID read
    scan_dr({24'd0, PAT}, 32, dout, oe_all);
    check("R8 idcode after reset", dout, {32'd0, IDV});
    check("R4 oe during dr shift", {63'd0, oe_all}, 64'd1);
    check("R4 oe after scan", {63'd0, tdo_oe}, 64'd0);

    // R5 R6 R7 R9 R10 instruction table
    for (int k = 0; k < 7; k++) begin
      u0 = upd_cnt;
      scan_ir(ITAB[k][8:4], irout, oe_all);
      check("R5 ir capture pattern", {59'd0, irout}, 64'd1);
      check("R4 oe during ir shift", {63'd0, oe_all}, 64'd1);
      check("R10 mode", {62'd0, bsr_mode}, {62'd0, ITAB[k][1:0]});
      scan_dr({24'd0, PAT}, 40, dout, oe_all);
      case (ITAB[k][3:2])
        2'd0: check("R7 R6 bypass path", dout, {24'd0, PAT[38:0], 1'b0});
        2'd1: check("R8 R6 id path", dout, {24'd0, PAT[7:0], IDV});
        default: check("R9 R6 chain path", dout, {24'd0, PAT[35:0], 4'hA});
      endcase
      check("R9 update strobes", 64'(upd_cnt - u0), (ITAB[k][3:2] == 2'd2) ? 64'd1 : 64'd0);
      check("R11 mode after dr scan", {62'd0, bsr_mode}, {62'd0, ITAB[k][1:0]});
    end

    // R11 mode holds through IR capture/shift/pause
    scan_ir(5'h00, irout, oe_all);
    step(1'b1, 1'b0, so, oe);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    for (int i = 0; i < 5; i++) step(i == 4, 5'h03 >> i, so, oe);
    step(1'b0, 1'b0, so, oe);
    check("R11 pause ir state", {60'd0, tap_state}, 64'd13);
    check("R11 mode held mid scan", {62'd0, bsr_mode}, 64'd1);
    step(1'b1, 1'b0, so, oe);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    check("R11 mode after update", {62'd0, bsr_mode}, 64'd2);

    // R12 DR scan split by pause under IDCODE
    scan_ir(5'h01, irout, oe_all);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    dout = '0;
    for (int i = 0; i < 16; i++) begin
      step(i == 15, 1'b0, so, oe);
      dout[i] = so;
    end
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    check("R12 pause dr state", {60'd0, tap_state}, 64'd6);
    check("R4 oe low in pause", {63'd0, tdo_oe}, 64'd0);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    for (int i = 16; i < 32; i++) begin
      step(i == 31, 1'b0, so, oe);
      dout[i] = so;
    end
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    check("R12 split id scan", dout, {32'd0, IDV});

    // R2 five high edges from IR shift, with BYPASS loaded first
    scan_ir(5'h1F, irout, oe_all);
    step(1'b1, 1'b0, so, oe);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, so, oe);
    check("R2 not yet reset after four", {60'd0, tap_state}, 64'd9);
    step(1'b1, 1'b0, so, oe);
    check("R2 reset after five", {60'd0, tap_state}, 64'd0);
    step(1'b0, 1'b0, so, oe);
    scan_dr({24'd0, PAT}, 32, dout, oe_all);
    check("R3 reset state loads idcode", dout, {32'd0, IDV});

    // R2 from DR pause
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, so, oe);
    check("R2 reset from dr pause", {60'd0, tap_state}, 64'd0);
    step(1'b0, 1'b0, so, oe);

    // R3 asynchronous reset during DR shift with EXTEST active
    scan_ir(5'h00, irout, oe_all);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    check("R4 oe in dr shift", {63'd0, tdo_oe}, 64'd1);
    tms = 1'b1;
    trst_n = 1'b0;
    #0.5;
    check("R3 async state", {60'd0, tap_state}, 64'd0);
    check("R3 async oe", {63'd0, tdo_oe}, 64'd0);
    check("R3 async mode", {62'd0, bsr_mode}, 64'd0);
    @(negedge tck);
    @(negedge tck);
    #0.5;
    trst_n = 1'b1;
    step(1'b0, 1'b0, so, oe);
    scan_dr({24'd0, PAT}, 32, dout, oe_all);
    check("R3 idcode after trst", dout, {32'd0, IDV});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule